// File: doc/BRIEF.md
# Serial Flash Master with Word Transfers

This block is a serial peripheral interface master for a single flash device, controlled through four word-wide registers on a simple synchronous register bus. Software places words into a four-entry transmit queue, programs a transfer length of 1 to 32 bits and the clock polarity and phase, and then sets a start bit. The engine takes one word from the queue and shifts the selected low-order bits out most significant bit first. The bits that arrive on the input line during the transfer are collected into a right-aligned word and pushed into a four-entry receive queue.

Chip select can be driven by software through a command bit. This lets a flash command, its address and its data phases stay under one continuous select. Without software control, select is active for as long as a transfer is pending or running. Sticky status flags record completion, transmit overflow and receive underrun, and each is cleared by writing 1 to it. Two self-clearing status bits empty either queue in a single cycle. The serial clock half period is a whole number of system clocks set by a parameter. It is chosen at integration so that the serial clock stays at or below 52 MHz.

Top module: `spiflash_master`

## Requirements
- R1: After reset the status register reads 0x0280_0000 (both queues empty, nothing else set), the command register reads 0, select is high and the serial clock is low.
- R2: The command register is at offset 0x00, status at 0x04, transmit write port at 0x10 and receive read port at 0x20. Offsets 0x14 to 0x1F read 0. Command bits 27:26, 19:18, 15:12 and 4:0 read back as written, and every other command bit reads 0.
- R3: A transfer sends bits [L:0] of the transmit word most significant bit first, where L is command bits 4:0. The L+1 bits received are pushed right-aligned, with zeros above them, into the receive queue.
- R4: Status bit 31 (busy) is 1 from the start write until the transfer ends. Status bit 30 (ready) then sets. Writing 1 to bit 30 clears it, and writing 0 leaves it set.
- R5: Command bit 30 (start) always reads 0. A start written while busy is ignored: no second word is taken and no second result is produced.
- R6: A write to the transmit port while four words are held sets status bit 26 (overflow) and discards the word. Bit 22 reports a full transmit queue. Writing 1 to bit 26 clears it.
- R7: Reading the receive port while it is empty returns 0 and sets status bit 27 (underrun). Writing 1 to bit 27 clears it.
- R8: Writing 1 to status bit 28 empties the transmit queue, and writing 1 to bit 29 empties the receive queue. Both bits read 0. Status bits 23 and 25 report an empty transmit and receive queue.
- R9: With command bit 12 set, select follows the inverse of command bit 13. With bit 12 clear, select is low only while a transfer is pending or running.
- R10: Command bit 26 sets the idle level of the serial clock. Command bit 18 selects the sampling edge: the leading edge when it is 0, the trailing edge when it is 1. Output data changes on the other edge.
- R11: With command bit 15 (transmit enable) clear, zeros are shifted out and the transmit queue is left untouched. With command bit 14 (receive enable) clear, the received word is discarded.
- R12: Each serial clock half period lasts HALF_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive port) |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench loops the data output back to the data input. It captures the output line on the edge where the flash would sample it in each clock mode. A design that swapped the phase handling, or shifted on the first leading edge, therefore shows a misaligned bit pattern even when the loopback word looks correct. Lengths of 8, 12 and 32 bits, with junk above the selected bits, expose wrong alignment of the transmit word or leftover upper bits in the received word. A second start written mid-transfer must leave the second queued word in place. A design that re-armed would consume it and produce an extra result. Overflow, underrun and flush are exercised at the queue boundaries: a fifth word must not replace the fourth, and a zero written to the status register must not clear the sticky flags.

// File: rtl/spiflash_pkg.sv
package spiflash_pkg;

    localparam logic [5:0] OFS_CMD  = 6'h00;
    localparam logic [5:0] OFS_STAT = 6'h04;
    localparam logic [5:0] OFS_TXD  = 6'h10;
    localparam logic [5:0] OFS_RXD  = 6'h20;

    localparam int B_START   = 30;
    localparam int B_BUSY    = 31;
    localparam int B_READY   = 30;
    localparam int B_RXFLUSH = 29;
    localparam int B_TXFLUSH = 28;
    localparam int B_UFLOW   = 27;
    localparam int B_OFLOW   = 26;

    typedef struct packed {
        logic [1:0] clk_lvl;   // bits 27:26, bit 26 = idle level
        logic [1:0] smp_edge;  // bits 19:18, bit 18 = trailing-edge sampling
        logic       tx_en;     // bit 15
        logic       rx_en;     // bit 14
        logic       sel_val;   // bit 13
        logic       sel_sw;    // bit 12
        logic [4:0] nbits_m1;  // bits 4:0
    } cmd_t;

endpackage

// File: rtl/spif_fifo.sv
module spif_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic         flush,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_t;

    fifo_t          st_d, st_q;
    logic [W-1:0]   mem_q [DEPTH];
    logic           push_ok, pop_ok;

    assign empty   = (st_q.cnt == '0);
    assign full    = (st_q.cnt == CNT_FULL);
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign rdata   = empty ? '0 : mem_q[st_q.rp];

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (push_ok) st_d.wp = st_q.wp + 1'b1;
            if (pop_ok)  st_d.rp = st_q.rp + 1'b1;
            if (push_ok && !pop_ok) st_d.cnt = st_q.cnt + 1'b1;
            if (pop_ok && !push_ok) st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wp] <= wdata;
    end

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_FULL);

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full);

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/spif_shifter.sv
module spif_shifter #(
    parameter int HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [4:0]  nbits_m1,
    input  logic        cpol,
    input  logic        cpha,
    input  logic [31:0] tx_word,
    input  logic        miso,
    output logic        sck,
    output logic        mosi,
    output logic        busy,
    output logic        done,
    output logic [31:0] rx_word
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic          lvl;
        logic          pha;
        logic [DW-1:0] div;
        logic [5:0]    edg_cnt;
        logic [5:0]    edg_last;
        logic [31:0]   sh;
        logic [31:0]   rx;
    } eng_t;

    eng_t st_d, st_q;
    logic tick, lead;

    assign tick = st_q.busy && (st_q.div == DIV_LAST);
    assign lead = ~st_q.edg_cnt[0];

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy     = 1'b1;
                st_d.lvl      = cpol;
                st_d.pha      = cpha;
                st_d.div      = '0;
                st_d.edg_cnt  = '0;
                st_d.edg_last = {nbits_m1, 1'b1};
                st_d.sh       = tx_word << (5'd31 - nbits_m1);
                st_d.rx       = '0;
            end
        end else if (tick) begin
            st_d.div = '0;
            st_d.lvl = ~st_q.lvl;
            if (lead ^ st_q.pha) begin
                st_d.rx = {st_q.rx[30:0], miso};
            end else if (st_q.edg_cnt != '0) begin
                st_d.sh = {st_q.sh[30:0], 1'b0};
            end
            if (st_q.edg_cnt == st_q.edg_last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.edg_cnt = st_q.edg_cnt + 1'b1;
            end
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sck     = st_q.busy ? st_q.lvl : cpol;
    assign mosi    = st_q.sh[31];
    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign rx_word = st_q.rx;

    assert_half_period_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !tick) |=> (st_q.busy && $stable(st_q.lvl)));

    assert_done_ends_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (!st_q.busy && $past(st_q.busy)));

endmodule

// File: rtl/spiflash_master.sv
module spiflash_master
    import spiflash_pkg::*;
#(
    parameter int HALF_DIV   = 2,
    parameter int FIFO_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        spi_sck,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    typedef struct packed {
        cmd_t cmd;
        logic go;
        logic ready;
        logic uflow;
        logic oflow;
    } ctl_t;

    ctl_t        ctl_d, ctl_q;
    logic        wr_cmd, wr_stat, wr_txd, rd_rxd;
    logic        tx_flush, rx_flush, tx_pop, rx_push;
    logic        tx_empty, tx_full, rx_empty, rx_full;
    logic [31:0] tx_head, rx_head, eng_tx_word, eng_rx_word;
    logic        eng_busy, eng_done, busy_all;

    assign wr_cmd   = bus_wr && (bus_addr == OFS_CMD);
    assign wr_stat  = bus_wr && (bus_addr == OFS_STAT);
    assign wr_txd   = bus_wr && (bus_addr == OFS_TXD);
    assign rd_rxd   = bus_rd && (bus_addr == OFS_RXD);
    assign tx_flush = wr_stat && bus_wdata[B_TXFLUSH];
    assign rx_flush = wr_stat && bus_wdata[B_RXFLUSH];
    assign busy_all = ctl_q.go || eng_busy || eng_done;

    assign tx_pop      = ctl_q.go && ctl_q.cmd.tx_en && !tx_empty;
    assign eng_tx_word = (ctl_q.cmd.tx_en && !tx_empty) ? tx_head : 32'h0;
    assign rx_push     = eng_done && ctl_q.cmd.rx_en;

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.go = 1'b0;
        if (wr_cmd) begin
            ctl_d.cmd.clk_lvl  = bus_wdata[27:26];
            ctl_d.cmd.smp_edge = bus_wdata[19:18];
            ctl_d.cmd.tx_en    = bus_wdata[15];
            ctl_d.cmd.rx_en    = bus_wdata[14];
            ctl_d.cmd.sel_val  = bus_wdata[13];
            ctl_d.cmd.sel_sw   = bus_wdata[12];
            ctl_d.cmd.nbits_m1 = bus_wdata[4:0];
            if (bus_wdata[B_START] && !busy_all) ctl_d.go = 1'b1;
        end
        if (wr_stat) begin
            if (bus_wdata[B_READY]) ctl_d.ready = 1'b0;
            if (bus_wdata[B_UFLOW]) ctl_d.uflow = 1'b0;
            if (bus_wdata[B_OFLOW]) ctl_d.oflow = 1'b0;
        end
        if (eng_done)              ctl_d.ready = 1'b1;
        if (rd_rxd && rx_empty)    ctl_d.uflow = 1'b1;
        if (wr_txd && tx_full)     ctl_d.oflow = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        unique case (bus_addr)
            OFS_CMD:  bus_rdata = {4'b0, ctl_q.cmd.clk_lvl, 6'b0, ctl_q.cmd.smp_edge, 2'b0,
                                   ctl_q.cmd.tx_en, ctl_q.cmd.rx_en, ctl_q.cmd.sel_val,
                                   ctl_q.cmd.sel_sw, 7'b0, ctl_q.cmd.nbits_m1};
            OFS_STAT: bus_rdata = {busy_all, ctl_q.ready, 2'b00, ctl_q.uflow, ctl_q.oflow,
                                   rx_empty, rx_full, tx_empty, tx_full, 22'b0};
            OFS_RXD:  bus_rdata = rx_head;
            default:  bus_rdata = 32'h0;
        endcase
    end

    assign spi_cs_n = ctl_q.cmd.sel_sw ? ~ctl_q.cmd.sel_val : ~busy_all;

    spif_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(wr_txd), .pop(tx_pop), .flush(tx_flush),
        .wdata(bus_wdata), .rdata(tx_head), .empty(tx_empty), .full(tx_full)
    );

    spif_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rd_rxd), .flush(rx_flush),
        .wdata(eng_rx_word), .rdata(rx_head), .empty(rx_empty), .full(rx_full)
    );

    spif_shifter #(.HALF_DIV(HALF_DIV)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(ctl_q.go), .nbits_m1(ctl_q.cmd.nbits_m1),
        .cpol(ctl_q.cmd.clk_lvl[0]), .cpha(ctl_q.cmd.smp_edge[0]), .tx_word(eng_tx_word),
        .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .busy(eng_busy), .done(eng_done),
        .rx_word(eng_rx_word)
    );

    assert_ready_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> ctl_q.ready);

    assert_start_ignored_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && bus_wdata[B_START] && busy_all) |=> !ctl_q.go);

    assert_underrun_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rxd && rx_empty) |=> ctl_q.uflow);

    assert_single_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.go |-> (!eng_busy && !eng_done));

endmodule

// File: tb/spiflash_master_test.sv
module spiflash_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sck, spi_cs_n, spi_mosi, spi_miso;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    localparam logic [5:0] A_CMD = 6'h00, A_STAT = 6'h04, A_TXD = 6'h10, A_RXD = 6'h20;
    localparam logic [31:0] GO = 32'h4000_0000;
    localparam logic [31:0] BASE = 32'h0000_F000;  // sw select, select on, tx, rx

    always #5 clk = ~clk;
    assign spi_miso = spi_mosi;

    spiflash_master uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // flash-side capture of the data line
    bit          mon_rise = 1;
    logic [31:0] mon_bits = '0;
    int          mon_cnt = 0;
    int          hi_run = 0;
    int          last_hi = 0;

    always @(posedge spi_sck) if (mon_rise) begin
        mon_bits = {mon_bits[30:0], spi_mosi}; mon_cnt++;
    end
    always @(negedge spi_sck) if (!mon_rise) begin
        mon_bits = {mon_bits[30:0], spi_mosi}; mon_cnt++;
    end
    always @(negedge clk) begin
        if (spi_sck) hi_run++;
        else begin
            if (hi_run != 0) last_hi = hi_run;
            hi_run = 0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_ready(output bit ok);
        logic [31:0] s;
        ok = 0;
        for (int i = 0; i < 400; i++) begin
            bus_read(A_STAT, s);
            if (s[30]) begin ok = 1; break; end
        end
    endtask

    task automatic run_xfer(input logic [31:0] cmd, input bit rise, output bit ok);
        bus_write(A_STAT, 32'h4000_0000);
        mon_rise = rise; mon_bits = '0; mon_cnt = 0;
        bus_write(A_CMD, cmd | GO);
        wait_ready(ok);
    endtask

    task automatic flush_all();
        bus_write(A_STAT, 32'h3C00_0000 | 32'h4000_0000);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_read(A_STAT, d);
        check(d == 32'h0280_0000, "R1 status after reset", d, 32'h0280_0000);
        bus_read(A_CMD, d);
        check(d == 0, "R1 command after reset", d, 0);
        check(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1 pins after reset",
              {30'b0, spi_cs_n, spi_sck}, 32'h2);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        bus_write(A_CMD, 32'h8C0C_F11F);
        bus_read(A_CMD, d);
        check(d == 32'h0C0C_F01F, "R2 command readback", d, 32'h0C0C_F01F);
        bus_read(6'h14, d);
        check(d == 0, "R2 reserved 0x14", d, 0);
        bus_read(6'h1C, d);
        check(d == 0, "R2 reserved 0x1C", d, 0);
        bus_write(A_CMD, 32'h0);
    endtask

    task automatic t_mode0_byte();
        logic [31:0] d, s;
        bit ok;
        bus_write(A_CMD, BASE | 32'd7);
        bus_write(A_TXD, 32'hFFFF_FFA5);
        bus_write(A_STAT, 32'h4000_0000);
        mon_rise = 1; mon_bits = '0; mon_cnt = 0;
        bus_write(A_CMD, BASE | 32'd7 | GO);
        bus_read(A_STAT, s);
        check(s[31] == 1'b1, "R4 busy after start", s, 32'h8000_0000);
        bus_read(A_CMD, d);
        check(d[30] == 1'b0, "R5 start reads zero", d, BASE | 32'd7);
        wait_ready(ok);
        check(ok, "R4 ready after transfer", {31'b0, ok}, 1);
        bus_read(A_STAT, s);
        check(s[31] == 1'b0, "R4 busy cleared", s, 32'h4000_0000);
        check(mon_cnt == 8 && mon_bits[7:0] == 8'hA5, "R3 byte MSB first",
              mon_bits, 32'hA5);
        check(last_hi == 2, "R12 half period", last_hi, 2);
        bus_read(A_RXD, d);
        check(d == 32'h0000_00A5, "R3 rx right aligned", d, 32'hA5);
        bus_write(A_STAT, 32'h0);
        bus_read(A_STAT, s);
        check(s[30] == 1'b1, "R4 write zero keeps ready", s, 32'h4000_0000);
        bus_write(A_STAT, 32'h4000_0000);
        bus_read(A_STAT, s);
        check(s[30] == 1'b0, "R4 write one clears ready", s, 0);
    endtask

    task automatic t_word32();
        logic [31:0] d;
        bit ok;
        bus_write(A_CMD, BASE | 32'd31);
        bus_write(A_TXD, 32'h8001_3CC5);
        run_xfer(BASE | 32'd31, 1, ok);
        check(ok && mon_cnt == 32 && mon_bits == 32'h8001_3CC5, "R3 32-bit word",
              mon_bits, 32'h8001_3CC5);
        bus_read(A_RXD, d);
        check(d == 32'h8001_3CC5, "R3 32-bit rx", d, 32'h8001_3CC5);
    endtask

    task automatic t_modes();
        logic [31:0] d;
        bit ok;
        // trailing-edge sampling, idle low: flash samples on falling edge
        bus_write(A_CMD, BASE | 32'h0004_0000 | 32'd11);
        bus_write(A_TXD, 32'h0000_5ABC);
        run_xfer(BASE | 32'h0004_0000 | 32'd11, 0, ok);
        check(ok && mon_cnt == 12 && mon_bits[11:0] == 12'hABC, "R10 trailing sample",
              mon_bits, 32'hABC);
        bus_read(A_RXD, d);
        check(d == 32'h0000_0ABC, "R10 trailing sample rx", d, 32'hABC);
        // idle high, leading-edge sampling: leading edge is falling
        bus_write(A_CMD, BASE | 32'h0400_0000 | 32'd11);
        check(spi_sck == 1'b1, "R10 idle level high", {31'b0, spi_sck}, 1);
        bus_write(A_TXD, 32'h0000_0963);
        run_xfer(BASE | 32'h0400_0000 | 32'd11, 0, ok);
        check(ok && mon_cnt == 12 && mon_bits[11:0] == 12'h963, "R10 idle high leading",
              mon_bits, 32'h963);
        check(spi_sck == 1'b1, "R10 idle high after", {31'b0, spi_sck}, 1);
        bus_read(A_RXD, d);
        check(d == 32'h0000_0963, "R10 idle high rx", d, 32'h963);
        bus_write(A_CMD, BASE);
    endtask

    task automatic t_overflow();
        logic [31:0] d, s;
        bit ok;
        flush_all();
        for (int i = 1; i <= 5; i++) bus_write(A_TXD, 32'(i));
        bus_read(A_STAT, s);
        check(s[26] && s[22], "R6 overflow and full", s, 32'h0440_0000);
        bus_write(A_STAT, 32'h0);
        bus_read(A_STAT, s);
        check(s[26] == 1'b1, "R6 zero write keeps overflow", s, 32'h0400_0000);
        for (int i = 1; i <= 4; i++) begin
            run_xfer(BASE | 32'd7, 1, ok);
            bus_read(A_RXD, d);
            check(ok && d == 32'(i), "R6 stored words intact", d, 32'(i));
        end
        bus_read(A_STAT, s);
        check(s[23] == 1'b1, "R6 fifth word dropped", s, 32'h0080_0000);
        bus_write(A_STAT, 32'h0400_0000);
        bus_read(A_STAT, s);
        check(s[26] == 1'b0, "R6 overflow cleared", s, 0);
    endtask

    task automatic t_underrun();
        logic [31:0] d, s;
        flush_all();
        bus_read(A_RXD, d);
        check(d == 0, "R7 empty read zero", d, 0);
        bus_read(A_STAT, s);
        check(s[27] == 1'b1, "R7 underrun set", s, 32'h0800_0000);
        bus_write(A_STAT, 32'h0800_0000);
        bus_read(A_STAT, s);
        check(s[27] == 1'b0, "R7 underrun cleared", s, 0);
    endtask

    task automatic t_flush();
        logic [31:0] s;
        bit ok;
        flush_all();
        bus_write(A_TXD, 32'h11);
        bus_write(A_TXD, 32'h22);
        run_xfer(BASE | 32'd7, 1, ok);
        bus_read(A_STAT, s);
        check(ok && s[23] == 0 && s[25] == 0, "R8 both queues hold data", s, 0);
        bus_write(A_STAT, 32'h1000_0000);
        bus_read(A_STAT, s);
        check(s[23] == 1 && s[25] == 0 && s[28] == 0, "R8 tx flush", s, 32'h0080_0000);
        bus_write(A_STAT, 32'h2000_0000);
        bus_read(A_STAT, s);
        check(s[25] == 1 && s[29] == 0, "R8 rx flush", s, 32'h0280_0000);
    endtask

    task automatic t_select();
        bus_write(A_CMD, 32'h0000_1000);
        check(spi_cs_n == 1'b1, "R9 sw select off", {31'b0, spi_cs_n}, 1);
        bus_write(A_CMD, 32'h0000_3000);
        check(spi_cs_n == 1'b0, "R9 sw select on", {31'b0, spi_cs_n}, 0);
        bus_write(A_CMD, 32'h0000_2000);
        check(spi_cs_n == 1'b1, "R9 hw select idle", {31'b0, spi_cs_n}, 1);
        bus_write(A_CMD, BASE);
    endtask

    task automatic t_enables();
        logic [31:0] d, s;
        bit ok;
        flush_all();
        bus_write(A_TXD, 32'hFF);
        bus_write(A_CMD, 32'h0000_7007);
        run_xfer(32'h0000_7007, 1, ok);
        check(ok && mon_cnt == 8 && mon_bits[7:0] == 8'h00, "R11 tx disabled zeros",
              mon_bits, 0);
        bus_read(A_STAT, s);
        check(s[23] == 1'b0, "R11 tx queue untouched", s, 0);
        bus_read(A_RXD, d);
        check(d == 0, "R11 rx of zeros", d, 0);
        bus_write(A_CMD, 32'h0000_B007);
        run_xfer(32'h0000_B007, 1, ok);
        bus_read(A_STAT, s);
        check(ok && s[25] == 1'b1 && s[23] == 1'b1, "R11 rx disabled discards",
              s, 32'h0280_0000);
        bus_write(A_CMD, BASE);
    endtask

    task automatic t_go_busy();
        logic [31:0] d, s;
        bit ok;
        flush_all();
        bus_write(A_TXD, 32'h0000_0011);
        bus_write(A_TXD, 32'h0000_0022);
        bus_write(A_CMD, BASE | 32'd31);
        mon_rise = 1; mon_bits = '0; mon_cnt = 0;
        bus_write(A_CMD, BASE | 32'd31 | GO);
        bus_write(A_CMD, BASE | 32'd31 | GO);
        repeat (10) @(negedge clk);
        bus_write(A_CMD, BASE | 32'd31 | GO);
        wait_ready(ok);
        repeat (4) @(negedge clk);
        bus_read(A_STAT, s);
        check(ok && s[23] == 1'b0 && s[31] == 1'b0, "R5 start while busy ignored",
              s, 32'h4000_0000);
        bus_read(A_RXD, d);
        check(d == 32'h11, "R5 single result", d, 32'h11);
        bus_read(A_STAT, s);
        check(s[25] == 1'b1, "R5 no second result", s, 32'h0200_0000);
        flush_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_regmap();
        t_mode0_byte();
        t_word32();
        t_modes();
        t_overflow();
        t_underrun();
        t_flush();
        t_select();
        t_enables();
        t_go_busy();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule